// File: doc/BRIEF.md
# Microcontroller External Bus Demultiplexer with Display Port

This block connects a microcontroller with a multiplexed external bus to memory and one peripheral. During each external bus cycle the low address byte and the data share the same eight lines, and a separate port carries the high address byte. The block holds the low byte while the address-latch-enable strobe is high and keeps it after the strobe falls. It joins that byte with the high byte to form a 16-bit address and decodes the result.

The lower 32 KB of the address space is a byte-wide SRAM that holds both program code and data. The block drives its chip-select, output-enable and write-enable. It also drives the returned read data onto the shared lines, and only during SRAM read and fetch cycles. One write-only 8-bit display register sits at address 0x7F55, which lies inside the SRAM range. A write to that address loads the register and is kept away from the SRAM.

All strobes are sampled by a fast system clock. The write strobe's rising edge is found by comparing it with its value one clock earlier.

Top module: `ebus_demux`

## Requirements
- R1: While reset is held, and after it is released until the first qualifying write, the display output `seg` is 0x00.
- R2: While `ale` is high, the held low address byte follows `bus_in` one clock later. Once `ale` is low, changes on `bus_in` do not alter it.
- R3: `addr` equals `{addr_hi, held low byte}` at all times.
- R4: When `wr_n` rises while `addr` equals 0x7F55, `seg` takes the `bus_in` value from the strobe-low period one clock later. Bit 0 is segment a, and bits 1 to 6 are segments b to g in order.
- R5: A write strobe at any address other than 0x7F55 leaves `seg` unchanged. Examples are 0x7F54, 0xFF55, 0x7E55 and 0x2000.
- R6: When `addr[15]` is 0 and `rd_n` or `psen_n` is low, both `sram_cs_n` and `sram_oe_n` are 0. When `addr[15]` is 1, both are 1.
- R7: When `addr[15]` is 0, `wr_n` is low and `addr` is not 0x7F55, `sram_we_n` and `sram_cs_n` are 0. At 0x7F55, `sram_we_n` and `sram_cs_n` stay 1.
- R8: `bus_oe` is 1, with `bus_out` equal to `sram_rdata`, only during SRAM read or fetch cycles. In every other case `bus_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock sampling the bus strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address latch enable, high while the low address byte is on the shared lines |
| rd_n | input | 1 | Data read strobe, active low |
| wr_n | input | 1 | Data write strobe, active low |
| psen_n | input | 1 | Program fetch strobe, active low |
| bus_in | input | 8 | Shared address/data lines, input side |
| addr_hi | input | 8 | High address byte |
| sram_rdata | input | 8 | Read data returned by the SRAM |
| addr | output | 16 | Rebuilt 16-bit address |
| sram_cs_n | output | 1 | SRAM chip-select, active low |
| sram_oe_n | output | 1 | SRAM output-enable, active low |
| sram_we_n | output | 1 | SRAM write-enable, active low |
| bus_out | output | 8 | Data driven onto the shared lines |
| bus_oe | output | 1 | Drive enable for the shared lines |
| seg | output | 8 | Display register, bit 0 = segment a |

## Verification
The bench writes to addresses that differ from 0x7F55 in one byte only: 0x7F54, 0x7E55 and 0xFF55. A decoder that compares only part of the address would load the display on one of these writes. It writes to 0x7F55 and checks that the SRAM write-enable and chip-select stay inactive there. A design that lets the SRAM see this write would corrupt the memory byte at the port's address. It changes the shared lines after the latch strobe falls, which shows whether the address still follows the data. It also checks that the shared lines are released during writes and above 32 KB, where a design that drives them would fight the processor.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 8;
  localparam int SRAM_AW   = 15;
  localparam logic [ADDR_W-1:0] PORT_ADDR = 16'h7F55;
endpackage

// File: rtl/ebus_addr_latch.sv
module ebus_addr_latch #(
  parameter int LO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ale,
  input  logic [LO_W-1:0] bus_in,
  output logic [LO_W-1:0] lo_q
);
  logic [LO_W-1:0] lo_d;

  always_comb begin
    lo_d = lo_q;
    if (ale) lo_d = bus_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_q <= '0;
    else        lo_q <= lo_d;
  end

  p_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> lo_q == $past(bus_in));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ale |=> $stable(lo_q));
endmodule

// File: rtl/ebus_decode.sv
module ebus_decode #(
  parameter int              ADDR_W    = 16,
  parameter int              SRAM_AW   = 15,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h7F55
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              psen_n,
  output logic              sram_cs_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic              port_hit,
  output logic              bus_drive
);
  localparam int HI_W = ADDR_W - SRAM_AW;

  logic in_sram, rd_cyc, wr_cyc;

  always_comb begin
    in_sram   = (addr[ADDR_W-1 -: HI_W] == '0);
    port_hit  = (addr == PORT_ADDR);
    rd_cyc    = in_sram && (!rd_n || !psen_n);
    wr_cyc    = in_sram && !wr_n && !port_hit;
    sram_oe_n = !rd_cyc;
    sram_we_n = !wr_cyc;
    sram_cs_n = !(rd_cyc || wr_cyc);
    bus_drive = rd_cyc;
  end

  always_comb begin
    p_no_port_we_r7: assert (!(!sram_we_n && port_hit));
    p_oe_needs_cs_r6: assert (sram_oe_n || !sram_cs_n);
    p_drive_matches_oe_r8: assert (bus_drive == !sram_oe_n);
  end
endmodule

// File: rtl/ebus_seg_port.sv
module ebus_seg_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              port_hit,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] seg
);
  logic              wr_q;
  logic [DATA_W-1:0] dat_q;
  logic              wr_rise, load_en;
  logic [DATA_W-1:0] seg_d;

  always_comb begin
    wr_rise = wr_n && !wr_q;
    load_en = wr_rise && port_hit;
    seg_d   = seg;
    if (load_en) seg_d = dat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= 1'b1;
      dat_q <= '0;
      seg   <= '0;
    end else begin
      wr_q  <= wr_n;
      dat_q <= bus_in;
      seg   <= seg_d;
    end
  end

  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_n && !wr_q && port_hit) |=> seg == $past(dat_q));
  p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_n && !wr_q && port_hit) |=> $stable(seg));
endmodule

// File: rtl/ebus_demux.sv
module ebus_demux
  import ebus_pkg::*;
#(
  parameter int                ADDR_W    = ebus_pkg::ADDR_W,
  parameter int                DATA_W    = ebus_pkg::DATA_W,
  parameter int                SRAM_AW   = ebus_pkg::SRAM_AW,
  parameter logic [ADDR_W-1:0] PORT_ADDR = ebus_pkg::PORT_ADDR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              psen_n,
  input  logic [DATA_W-1:0] bus_in,
  input  logic [ADDR_W-DATA_W-1:0] addr_hi,
  input  logic [DATA_W-1:0] sram_rdata,
  output logic [ADDR_W-1:0] addr,
  output logic              sram_cs_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic [DATA_W-1:0] seg
);
  logic              rst_meta, rst_sync_n;
  logic [DATA_W-1:0] lo_q;
  logic              port_hit, bus_drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  ebus_addr_latch #(.LO_W(DATA_W)) u_latch (
    .clk(clk), .rst_n(rst_sync_n), .ale(ale), .bus_in(bus_in), .lo_q(lo_q)
  );

  always_comb addr = {addr_hi, lo_q};

  ebus_decode #(.ADDR_W(ADDR_W), .SRAM_AW(SRAM_AW), .PORT_ADDR(PORT_ADDR)) u_dec (
    .addr(addr), .rd_n(rd_n), .wr_n(wr_n), .psen_n(psen_n),
    .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .port_hit(port_hit), .bus_drive(bus_drive)
  );

  ebus_seg_port #(.DATA_W(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_sync_n), .wr_n(wr_n), .port_hit(port_hit),
    .bus_in(bus_in), .seg(seg)
  );

  always_comb begin
    bus_oe  = bus_drive;
    bus_out = bus_drive ? sram_rdata : '0;
  end

  p_addr_join_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    addr[ADDR_W-1:DATA_W] == addr_hi);
  p_high_idle_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    addr[ADDR_W-1] |-> (sram_cs_n && !bus_oe));
endmodule

// File: tb/test_ebus_demux.sv
module test_ebus_demux;
  logic        clk = 1'b0;
  logic        rst_n, ale, rd_n, wr_n, psen_n;
  logic [7:0]  bus_in, addr_hi, sram_rdata;
  logic [15:0] addr;
  logic        sram_cs_n, sram_oe_n, sram_we_n, bus_oe;
  logic [7:0]  bus_out, seg;
  int          n_chk = 0;
  int          n_err = 0;

  always #2 clk = ~clk;

  ebus_demux i_ebus_demux (
    .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .psen_n(psen_n),
    .bus_in(bus_in), .addr_hi(addr_hi), .sram_rdata(sram_rdata), .addr(addr),
    .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .bus_out(bus_out), .bus_oe(bus_oe), .seg(seg)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic addr_phase(input logic [15:0] a);
    @(negedge clk);
    ale = 1'b1; addr_hi = a[15:8]; bus_in = a[7:0];
    @(negedge clk);
    ale = 1'b0; bus_in = 8'h00;
  endtask

  task automatic write_cyc(input logic [15:0] a, input logic [7:0] d);
    addr_phase(a);
    bus_in = d; wr_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; ale = 0; rd_n = 1; wr_n = 1; psen_n = 1;
    bus_in = 8'h00; addr_hi = 8'h00; sram_rdata = 8'hA5;
    repeat (3) @(negedge clk);
    check("R1 seg in reset", {8'h0, seg}, 16'h0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 seg after release", {8'h0, seg}, 16'h0000);
    check("R8 bus released when idle", {15'h0, bus_oe}, 16'h0000);
  endtask

  task automatic t_latch;
    addr_phase(16'h12C3);
    #1;
    check("R3 addr rebuilt", addr, 16'h12C3);
    bus_in = 8'h9E;
    @(negedge clk); #1;
    check("R2 low byte held after ale falls", addr, 16'h12C3);
    addr_hi = 8'h45;
    #1;
    check("R3 high byte follows addr_hi", addr, 16'h45C3);
  endtask

  task automatic t_port_write;
    write_cyc(16'h7F55, 8'h3F);
    check("R4 port load digit 0", {8'h0, seg}, 16'h003F);
    check("R4 segment a on bit 0", {15'h0, seg[0]}, 16'h0001);
    check("R4 segment g on bit 6", {15'h0, seg[6]}, 16'h0000);
    write_cyc(16'h7F55, 8'h06);
    check("R4 port load digit 1", {8'h0, seg}, 16'h0006);
  endtask

  task automatic t_other_writes;
    write_cyc(16'h7F54, 8'hFF);
    check("R5 write 7F54 ignored", {8'h0, seg}, 16'h0006);
    write_cyc(16'hFF55, 8'hFF);
    check("R5 write FF55 ignored", {8'h0, seg}, 16'h0006);
    write_cyc(16'h7E55, 8'hFF);
    check("R5 write 7E55 ignored", {8'h0, seg}, 16'h0006);
    write_cyc(16'h2000, 8'h77);
    check("R5 write 2000 ignored", {8'h0, seg}, 16'h0006);
  endtask

  task automatic t_sram_read;
    addr_phase(16'h1234);
    sram_rdata = 8'h5A; rd_n = 1'b0; #1;
    check("R6 read cs", {15'h0, sram_cs_n}, 16'h0000);
    check("R6 read oe", {15'h0, sram_oe_n}, 16'h0000);
    check("R8 read drives bus", {7'h0, bus_oe, bus_out}, 16'h015A);
    rd_n = 1'b1;
    addr_phase(16'h0040);
    psen_n = 1'b0; #1;
    check("R6 fetch cs/oe", {14'h0, sram_cs_n, sram_oe_n}, 16'h0000);
    check("R8 fetch drives bus", {15'h0, bus_oe}, 16'h0001);
    psen_n = 1'b1;
    addr_phase(16'h8000);
    rd_n = 1'b0; #1;
    check("R6 high half cs/oe idle", {14'h0, sram_cs_n, sram_oe_n}, 16'h0003);
    check("R8 high half bus released", {15'h0, bus_oe}, 16'h0000);
    rd_n = 1'b1;
  endtask

  task automatic t_sram_write;
    addr_phase(16'h2000);
    bus_in = 8'h11; wr_n = 1'b0; #1;
    check("R7 write cs/we", {14'h0, sram_cs_n, sram_we_n}, 16'h0000);
    check("R8 write bus released", {14'h0, bus_oe, sram_oe_n}, 16'h0001);
    @(negedge clk); wr_n = 1'b1;
    addr_phase(16'h7F55);
    bus_in = 8'h5B; wr_n = 1'b0; #1;
    check("R7 port write keeps SRAM idle", {14'h0, sram_cs_n, sram_we_n}, 16'h0003);
    @(negedge clk); @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk); #1;
    check("R4 port load digit 2", {8'h0, seg}, 16'h005B);
  endtask

  initial begin
    t_reset();
    t_latch();
    t_port_write();
    t_other_writes();
    t_sram_read();
    t_sram_write();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule